// File: doc/BRIEF.md
# Clocked Retriggerable Monostable

This block produces a single high pulse on `q_o`, with `q_n_o` as its exact complement, each time a qualified trigger is seen. The pulse length is a count of clock cycles held in an internal width register, loaded from a parallel input, so no external timing parts are needed. Two trigger pins of opposite polarity gate each other: an active-low arm pin and an active-high arm pin. An active-low clear pin both forces the output idle and blocks triggering.

The three pins are sampled synchronously. Each passes through a two-stage synchronizer before edge detection. As a result, `q_o` goes high on the third rising clock edge after a qualifying pin change that was set up before the next edge. The same fixed latency applies to a pulse start, a retrigger extension and a clear. A mode pin selects between two behaviours: a retrigger restarts the full width, or triggers that arrive during a pulse are ignored.

Top module: `one_shot_gen`

## Requirements
- R1: After reset, `q_o` is 0 and `q_n_o` is 1.
- R2: While the synchronized clear is low, `q_o` stays 0 and `q_n_o` stays 1 whatever the trigger pins do. Driving clear low during a pulse ends that pulse.
- R3: No trigger occurs while `trig_lo_n_i` is high or while `trig_hi_i` is low. For example, a rising `trig_hi_i` with `trig_lo_n_i` high gives no pulse, and a falling `trig_lo_n_i` with `trig_hi_i` low gives no pulse.
- R4: A rising edge of `trig_hi_i` while `trig_lo_n_i` is low and clear is high starts a pulse. `q_o` stays 1 for exactly W cycles and then returns to 0.
- R5: A falling edge of `trig_lo_n_i` while `trig_hi_i` is high and clear is high starts a pulse of W cycles.
- R6: A rising edge of clear while `trig_lo_n_i` is low and `trig_hi_i` is high starts a pulse of W cycles.
- R7: With `retrig_i`=1, a trigger during a pulse restarts it, and the pulse ends W cycles after the new trigger.
- R8: With `retrig_i`=0, a trigger during a pulse is ignored, and the pulse ends W cycles after its first trigger.
- R9: A width of 0 produces no pulse.
- R10: A qualifying pin change driven before clock edge n makes `q_o` high from edge n+2 onward, which is the third edge counting edge n.
- R11: `width_ld_i`=1 loads `width_i` into the width register at the clock edge. A pulse already running keeps its length, and the next trigger uses the new width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n_i | input | 1 | Active-low clear; its rising edge can trigger |
| trig_lo_n_i | input | 1 | Active-low trigger pin (falling edge fires) |
| trig_hi_i | input | 1 | Active-high trigger pin (rising edge fires) |
| retrig_i | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| width_i | input | CNT_W | Pulse width in clock cycles |
| width_ld_i | input | 1 | Load strobe for the width register |
| q_o | output | 1 | Pulse output, active high |
| q_n_o | output | 1 | Complement of `q_o` |

## Verification
The pulse is started in three ways: by a rising edge of the high pin, by a falling edge of the low pin, and by clear going high. This shows that each edge source is decoded separately. Edges made while the other pin holds the block disarmed must produce nothing, which separates real gating from plain edge detection.

The same retrigger sequence is run in both modes. It is expected to give one stretched pulse in one mode and a pulse of the original length in the other. Further runs cover a clear that cuts a pulse short, toggling during clear, a width change in mid-pulse, and a width of zero. Each of these separates the width register, the counter and the clear path from one another.

// File: rtl/one_shot_pkg.sv
package one_shot_pkg;

    typedef enum logic {
        OS_NONRETRIG = 1'b0,
        OS_RETRIG    = 1'b1
    } os_mode_e;

    // Sampled pin bundle; order matters only for the idle constant below.
    typedef struct packed {
        logic arm_n;   // active-low trigger pin
        logic arm;     // active-high trigger pin
        logic clr_n;   // active-low clear
    } os_pins_t;

    localparam os_pins_t OS_PINS_IDLE = '{arm_n: 1'b1, arm: 1'b0, clr_n: 1'b1};
    localparam int       OS_SYNC_STAGES = 2;

    // The block is "enabled" when disarm conditions are all absent; a trigger
    // is the moment it becomes enabled from a state where it was not.
    function automatic logic os_enabled(os_pins_t p);
        return p.clr_n & ~p.arm_n & p.arm;
    endfunction

    function automatic logic os_fire(os_pins_t cur, os_pins_t prev);
        return os_enabled(cur) & ~os_enabled(prev);
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int               N_BITS  = 3,
    parameter int               STAGES  = 2,
    parameter logic [N_BITS-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BITS-1:0] d_i,
    output logic [N_BITS-1:0] q_o
);
    logic [N_BITS-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/os_trig_detect.sv
module os_trig_detect
    import one_shot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  os_pins_t pins_i,
    output logic     fire_o,
    output logic     clr_act_o
);
    os_pins_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= OS_PINS_IDLE;
        else     prev_q <= pins_i;
    end

    assign fire_o    = os_fire(pins_i, prev_q);
    assign clr_act_o = ~pins_i.clr_n;

    // R3: a disarming level on either trigger pin blocks any trigger
    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (pins_i.arm_n || !pins_i.arm) |-> !fire_o);
endmodule

// File: rtl/os_width_reg.sv
module os_width_reg #(
    parameter int               CNT_W = 16,
    parameter logic [CNT_W-1:0] RST_W = 16'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] width_i,
    output logic [CNT_W-1:0] width_o
);
    always_ff @(posedge clk) begin
        if (rst)       width_o <= RST_W;
        else if (ld_i) width_o <= width_i;
    end

    // R11: a load strobe captures the parallel input
    p_load_r11: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> width_o == $past(width_i));
endmodule

// File: rtl/os_width_timer.sv
module os_width_timer
    import one_shot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    input  logic             clr_act_i,
    input  os_mode_e         mode_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             may_load;

    assign may_load = fire_i && (width_i != '0) &&
                      (mode_i == OS_RETRIG || cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (clr_act_i)     cnt_q <= '0;
        else if (may_load)      cnt_q <= width_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end

    assign busy_o = (cnt_q != '0);

    // R2: an active clear leaves the timer idle on the next cycle
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clr_act_i |=> !busy_o);

    // R4: without trigger or clear a running pulse counts down by one
    p_span_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !fire_i && !clr_act_i) |=> cnt_q == $past(cnt_q) - ONE);

    // R7: a retrigger restarts from the full width
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (fire_i && mode_i == OS_RETRIG && !clr_act_i && width_i != '0)
        |=> cnt_q == $past(width_i));

    // R8: in non-retriggerable mode a running pulse ignores triggers
    p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_i == OS_NONRETRIG && busy_o && !clr_act_i)
        |=> cnt_q == $past(cnt_q) - ONE);

    // R9: zero width never starts a pulse
    p_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (fire_i && width_i == '0 && !busy_o && !clr_act_i) |=> !busy_o);
endmodule

// File: rtl/one_shot_gen.sv
module one_shot_gen
    import one_shot_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter int               SYNC_STAGES = OS_SYNC_STAGES,
    parameter logic [CNT_W-1:0] RST_WIDTH   = 16'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n_i,
    input  logic             trig_lo_n_i,
    input  logic             trig_hi_i,
    input  logic             retrig_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic             width_ld_i,
    output logic             q_o,
    output logic             q_n_o
);
    localparam int PIN_W = $bits(os_pins_t);

    os_pins_t         raw_pins, sync_pins;
    logic [PIN_W-1:0] sync_vec;
    logic             fire, clr_act, busy;
    logic [CNT_W-1:0] width_q;

    assign raw_pins = '{arm_n: trig_lo_n_i, arm: trig_hi_i, clr_n: clr_n_i};

    os_sync #(
        .N_BITS (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_W'(OS_PINS_IDLE))
    ) u_sync (
        .clk(clk), .rst(rst), .d_i(raw_pins), .q_o(sync_vec)
    );

    assign sync_pins = os_pins_t'(sync_vec);

    os_trig_detect u_detect (
        .clk(clk), .rst(rst), .pins_i(sync_pins),
        .fire_o(fire), .clr_act_o(clr_act)
    );

    os_width_reg #(.CNT_W(CNT_W), .RST_W(RST_WIDTH)) u_wreg (
        .clk(clk), .rst(rst), .ld_i(width_ld_i),
        .width_i(width_i), .width_o(width_q)
    );

    os_width_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .fire_i(fire), .clr_act_i(clr_act),
        .mode_i(os_mode_e'(retrig_i)), .width_i(width_q), .busy_o(busy)
    );

    assign q_o   = busy;
    assign q_n_o = ~busy;

    // R10: a pulse only begins right after the detector reported a trigger
    p_start_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(q_o) |-> $past(fire));
endmodule

// File: tb/one_shot_gen_tb.sv
`timescale 1ns/1ps
module one_shot_gen_tb_top;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clr_n = 1'b1, lo_n = 1'b1, hi = 1'b0, retrig = 1'b1;
    logic [CNT_W-1:0] width = 16'd5;
    logic             width_ld = 1'b0;
    logic             q, q_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    cyc;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    one_shot_gen #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .clr_n_i(clr_n), .trig_lo_n_i(lo_n),
        .trig_hi_i(hi), .retrig_i(retrig), .width_i(width),
        .width_ld_i(width_ld), .q_o(q), .q_n_o(q_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop expectations whose cycle has come, compare at negedge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.cyc != cyc) begin
                errors++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)",
                         e.tag, e.cyc, cyc);
            end else if (q !== e.val || q_n !== ~e.val) begin
                errors++;
                $display("FAIL %s: cycle %0d q=%b q_n=%b expected q=%b q_n=%b",
                         e.tag, cyc, q, q_n, e.val, ~e.val);
            end
        end
    end

    task automatic expect_span(int from, int to, logic v, string tag);
        for (int c = from; c <= to; c++) sb.push_back('{c, v, tag});
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic load_w(int v);
        width = CNT_W'(v);
        width_ld = 1'b1;
        @(negedge clk);
        width_ld = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int k;
        int j;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (q !== 1'b0 || q_n !== 1'b1) begin
            errors++;
            $display("FAIL R1: after reset q=%b q_n=%b expected q=0 q_n=1", q, q_n);
        end
        load_w(5);

        // R3: falling low pin while high pin is low -> nothing
        lo_n = 1'b0; k = cyc;
        expect_span(k + 1, k + 6, 1'b0, "R3");
        wait_until(k + 8);
        // R4 / R10: rising high pin with low pin low
        hi = 1'b1; k = cyc;
        expect_span(k + 1, k + 2, 1'b0, "R10");
        expect_span(k + 3, k + 7, 1'b1, "R4");
        expect_span(k + 8, k + 8, 1'b0, "R4");
        wait_until(k + 10);

        // R3: rising high pin while low pin high -> nothing
        hi = 1'b0; lo_n = 1'b1; k = cyc;
        wait_until(k + 4);
        hi = 1'b1; k = cyc;
        expect_span(k + 1, k + 6, 1'b0, "R3");
        wait_until(k + 7);
        // R5: falling low pin with high pin high
        lo_n = 1'b0; k = cyc;
        expect_span(k + 1, k + 2, 1'b0, "R10");
        expect_span(k + 3, k + 7, 1'b1, "R5");
        expect_span(k + 8, k + 8, 1'b0, "R5");
        wait_until(k + 10);

        // R2: toggling during clear gives nothing; R6: clear release fires
        clr_n = 1'b0; k = cyc;
        expect_span(k + 1, k + 12, 1'b0, "R2");
        wait_until(k + 3);  hi = 1'b0;
        wait_until(k + 6);  hi = 1'b1;
        wait_until(k + 12);
        clr_n = 1'b1; k = cyc;
        expect_span(k + 1, k + 2, 1'b0, "R6");
        expect_span(k + 3, k + 7, 1'b1, "R6");
        expect_span(k + 8, k + 8, 1'b0, "R6");
        wait_until(k + 10);

        // R2: clear cuts a running pulse short
        load_w(8);
        hi = 1'b0; k = cyc;
        wait_until(k + 4);
        hi = 1'b1; k = cyc;
        expect_span(k + 3, k + 7, 1'b1, "R2");
        wait_until(k + 5);  clr_n = 1'b0;
        wait_until(k + 6);  hi = 1'b0;
        expect_span(k + 8, k + 16, 1'b0, "R2");
        wait_until(k + 12); clr_n = 1'b1;
        wait_until(k + 17);

        // R7: retrigger stretches the pulse
        hi = 1'b1; k = cyc;
        expect_span(k + 1, k + 2, 1'b0, "R10");
        expect_span(k + 3, k + 16, 1'b1, "R7");
        expect_span(k + 17, k + 17, 1'b0, "R7");
        wait_until(k + 4);  hi = 1'b0;
        wait_until(k + 6);  hi = 1'b1;
        wait_until(k + 19);

        // R8: same sequence, non-retriggerable
        retrig = 1'b0; hi = 1'b0; k = cyc;
        wait_until(k + 4);
        hi = 1'b1; k = cyc;
        expect_span(k + 3, k + 10, 1'b1, "R8");
        expect_span(k + 11, k + 14, 1'b0, "R8");
        wait_until(k + 4);  hi = 1'b0;
        wait_until(k + 6);  hi = 1'b1;
        wait_until(k + 15);

        // R11: width change mid-pulse applies only to the next trigger
        retrig = 1'b1; hi = 1'b0; k = cyc;
        wait_until(k + 4);
        hi = 1'b1; k = cyc;
        expect_span(k + 3, k + 10, 1'b1, "R11");
        expect_span(k + 11, k + 11, 1'b0, "R11");
        wait_until(k + 4);
        load_w(3);
        wait_until(k + 12); hi = 1'b0;
        wait_until(k + 14);
        hi = 1'b1; j = cyc;
        expect_span(j + 3, j + 5, 1'b1, "R11");
        expect_span(j + 6, j + 6, 1'b0, "R11");
        wait_until(j + 8);

        // R9: zero width
        load_w(0);
        hi = 1'b0; k = cyc;
        wait_until(k + 4);
        hi = 1'b1; k = cyc;
        expect_span(k + 1, k + 8, 1'b0, "R9");
        wait_until(k + 10);

        while (sb.size() > 0) @(negedge clk);
        finish_run();
    end
endmodule